// File: doc/BRIEF.md
# Undefined-Length Burst Break-Point Generator

This block sits beside one client port of a multi-host bus matrix and watches the AHB-style address phase. When the host that currently owns the port issues an incrementing burst of undefined length, the block tells the arbiter after which beats the burst may be cut so that another host can be granted. The break points depend on a 3-bit split mode stored for each host. Non-zero modes cut the burst into power-of-two chunks of beats. Mode zero lets the burst run until a programmable client slot cycle limit is reached. In every mode, the beat just below a 1 KB address boundary is always a break point.

Each of the thirteen hosts has its own 32-bit configuration word at byte offset 4 times the host index. Only the mode field in bits 2:0 is stored. A write-protect input blocks all configuration writes while it is high. Fixed-length bursts, single transfers and idle cycles never create a break point. The arbiter uses `rearb_ok`, which is registered and therefore describes the beat accepted at the previous clock edge.

Top module: `ulb_break_limiter`

## Requirements
- R1: After reset, every host word reads 0x00000004 (16-beat split) and `rearb_ok` is low.
- R2: A write to byte offset 4*h with h below 13 stores `cfg_wdata[2:0]` as the mode of host h. A read of that offset returns the mode in bits 2:0 and zeros in bits 31:3.
- R3: While `cfg_wprot` is high, a write changes no host word.
- R4: A write to an offset whose word index is 13 or higher changes no host word, and a read there returns 0.
- R5: In mode 1 (single access), every accepted INCR beat raises `rearb_ok` on the next cycle.
- R6: In modes 2 to 7, with chunk size N = 2^mode (4, 8, 16, 32, 64, 128), `rearb_ok` rises after beat k exactly when k is a multiple of N. The NONSEQ beat counts as beat 1, and every NONSEQ restarts the count.
- R7: A cycle with `hready` low is not counted as a beat, and `rearb_ok` keeps its value through it.
- R8: In mode 0, `rearb_ok` rises after an accepted INCR beat when the number of clock cycles since the burst's NONSEQ was accepted (that cycle counting as 1, stalled cycles included) is at least `slot_limit`. A `slot_limit` of 0 disables this rule.
- R9: In any mode, an accepted INCR beat whose address has bits 9:2 all ones (the last word below a 1 KB boundary) raises `rearb_ok`.
- R10: An accepted transfer with `hburst` other than INCR (3'b001), or an IDLE cycle with `hready` high, clears `rearb_ok`. A BUSY cycle leaves it unchanged. Transfer codes are IDLE=0, BUSY=1, NONSEQ=2, SEQ=3.
- R11: The mode applied to a beat is the one stored for the host given on `host_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration byte offset, used for both read and write |
| cfg_wdata | input | 32 | Configuration write data; only bits 2:0 are kept |
| cfg_wprot | input | 1 | Write-protect enable; blocks writes when high |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| host_id | input | 4 | Index of the host that owns the current transfer |
| htrans | input | 2 | Transfer type |
| hburst | input | 3 | Burst type |
| haddr | input | 32 | Transfer address |
| hready | input | 1 | Transfer accepted when high |
| slot_limit | input | 8 | Client slot cycle limit used in mode 0 |
| rearb_ok | output | 1 | Registered break-point flag for the arbiter |

## Verification
`rearb_ok` is a single register, so it reflects the beat accepted at clock edge n during the cycle that follows edge n. A configuration write takes effect at the edge on which it is sampled, and `cfg_rdata` follows `cfg_addr` with no delay. The bench changes inputs on the falling edge. It then waits for the next rising edge plus 1 ns before it compares `rearb_ok` with the value it expects for the beat just driven, which it computes from the beat index, cycle count, mode and address. Register reads are checked 1 ns after the address is set, after the write has been given a full clock edge.

// File: rtl/ulb_pkg.sv
package ulb_pkg;

  localparam int MODE_W   = 3;
  localparam int MAX_SHIFT = 7;
  localparam int CNT_W    = $clog2(1 << MAX_SHIFT) + 1;

  localparam logic [1:0] TR_IDLE = 2'd0;
  localparam logic [1:0] TR_BUSY = 2'd1;
  localparam logic [1:0] TR_NSEQ = 2'd2;
  localparam logic [1:0] TR_SEQ  = 2'd3;

  localparam logic [2:0] BT_INCR = 3'b001;

  localparam logic [MODE_W-1:0] MODE_UNLIM  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_SINGLE = 3'd1;
  localparam logic [MODE_W-1:0] MODE_RESET  = 3'd4;

  typedef struct packed {
    logic acc;      // NONSEQ or SEQ taken with hready high
    logic nseq;     // transfer type is NONSEQ
    logic incr;     // burst type is undefined-length incrementing
    logic idle_acc; // IDLE seen with hready high
  } xfer_t;

  // Low-bit mask for a power-of-two chunk; all-zero means every beat.
  function automatic logic [CNT_W-1:0] chunk_mask(input logic [MODE_W-1:0] m);
    if (m <= MODE_SINGLE) return '0;
    return (CNT_W'(1) << m) - CNT_W'(1);
  endfunction

endpackage

// File: rtl/ulb_host_cfg.sv
module ulb_host_cfg
  import ulb_pkg::*;
#(
  parameter int NUM_HOSTS = 13,
  parameter int CFG_AW    = 6,
  parameter int DATA_W    = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                wprot,
  input  logic [CFG_AW-1:0]                   addr,
  input  logic [MODE_W-1:0]                   wmode,
  output logic [DATA_W-1:0]                   rdata,
  output logic [NUM_HOSTS-1:0][MODE_W-1:0]    modes
);

  localparam int IDX_W = CFG_AW - 2;

  logic [IDX_W-1:0]                  idx;
  logic                              in_range;
  logic [NUM_HOSTS-1:0]              wr_hit;
  logic [NUM_HOSTS-1:0][MODE_W-1:0]  mode_q;
  logic [NUM_HOSTS-1:0][MODE_W-1:0]  mode_d;

  assign idx      = addr[CFG_AW-1:2];
  assign in_range = 32'(idx) < NUM_HOSTS;

  for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
    assign wr_hit[h] = wr_en && !wprot && in_range && (idx == IDX_W'(h));
    assign mode_d[h] = wr_hit[h] ? wmode : mode_q[h];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < NUM_HOSTS; h++) mode_q[h] <= MODE_RESET;
    end else if (|wr_hit) begin
      mode_q <= mode_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int h = 0; h < NUM_HOSTS; h++) begin
      if (in_range && idx == IDX_W'(h)) rdata[MODE_W-1:0] = mode_q[h];
    end
  end

  assign modes = mode_q;

endmodule

// File: rtl/ulb_burst_track.sv
module ulb_burst_track
  import ulb_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  output xfer_t             xfer,
  output logic [CNT_W-1:0]  beat_nxt,
  output logic [SLOT_W-1:0] slot_nxt
);

  logic [CNT_W-1:0]  beat_q, beat_d;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_inc;
  logic              active_q, active_d;
  logic              start, finish;

  assign xfer.acc      = hready && htrans[1];
  assign xfer.nseq     = (htrans == TR_NSEQ);
  assign xfer.incr     = (hburst == BT_INCR);
  assign xfer.idle_acc = hready && (htrans == TR_IDLE);

  assign start  = xfer.acc && xfer.nseq && xfer.incr;
  assign finish = xfer.idle_acc || (xfer.acc && !xfer.incr);

  assign slot_inc = (&slot_q) ? slot_q : slot_q + SLOT_W'(1);
  assign beat_nxt = xfer.nseq ? CNT_W'(1) : beat_q + CNT_W'(1);
  assign slot_nxt = xfer.nseq ? SLOT_W'(1) : slot_inc;

  always_comb begin
    beat_d   = beat_q;
    slot_d   = slot_q;
    active_d = active_q;
    if (start) begin
      beat_d   = CNT_W'(1);
      slot_d   = SLOT_W'(1);
      active_d = 1'b1;
    end else if (finish) begin
      beat_d   = '0;
      slot_d   = '0;
      active_d = 1'b0;
    end else begin
      if (xfer.acc) beat_d = beat_nxt;
      if (active_q) slot_d = slot_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      slot_q   <= '0;
      active_q <= 1'b0;
    end else begin
      beat_q   <= beat_d;
      slot_q   <= slot_d;
      active_q <= active_d;
    end
  end

endmodule

// File: rtl/ulb_break_gen.sv
module ulb_break_gen
  import ulb_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_t             xfer,
  input  logic [MODE_W-1:0] mode,
  input  logic [CNT_W-1:0]  beat_nxt,
  input  logic [SLOT_W-1:0] slot_nxt,
  input  logic [SLOT_W-1:0] slot_limit,
  input  logic [SEG_W-1:0]  addr_seg,
  output logic              brk
);

  logic brk_q, brk_d, hit_split, hit_slot, hit_bound, brk_en;

  assign hit_split = (beat_nxt & chunk_mask(mode)) == '0;
  assign hit_slot  = (slot_limit != '0) && (slot_nxt >= slot_limit);
  assign hit_bound = &addr_seg;
  assign brk_en    = xfer.acc || xfer.idle_acc;

  always_comb begin
    brk_d = 1'b0;
    if (xfer.acc && xfer.incr) begin
      brk_d = hit_bound || ((mode == MODE_UNLIM) ? hit_slot : hit_split);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      brk_q <= 1'b0;
    else if (brk_en) brk_q <= brk_d;
  end

  assign brk = brk_q;

endmodule

// File: rtl/ulb_break_limiter.sv
module ulb_break_limiter
  import ulb_pkg::*;
#(
  parameter int NUM_HOSTS   = 13,
  parameter int HOST_W      = 4,
  parameter int ADDR_W      = 32,
  parameter int CFG_AW      = 6,
  parameter int DATA_W      = 32,
  parameter int SLOT_W      = 8,
  parameter int BOUND_BYTES = 1024,
  parameter int BEAT_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_wprot,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [HOST_W-1:0] host_id,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hready,
  input  logic [SLOT_W-1:0] slot_limit,
  output logic              rearb_ok
);

  localparam int BND_LSB = $clog2(BEAT_BYTES);
  localparam int BND_MSB = $clog2(BOUND_BYTES) - 1;
  localparam int SEG_W   = BND_MSB - BND_LSB + 1;

  logic [1:0]                         rst_pipe;
  logic                               rst_int;
  logic [NUM_HOSTS-1:0][MODE_W-1:0]   host_modes;
  logic [MODE_W-1:0]                  cur_mode;
  logic [SEG_W-1:0]                   bnd_seg;
  xfer_t                              xfer;
  logic [CNT_W-1:0]                   beat_nxt;
  logic [SLOT_W-1:0]                  slot_nxt;
  logic                               unused_bits;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  assign bnd_seg     = haddr[BND_MSB:BND_LSB];
  assign unused_bits = ^{haddr[ADDR_W-1:BND_MSB+1], haddr[BND_LSB-1:0],
                         cfg_wdata[DATA_W-1:MODE_W], cfg_addr[1:0]};

  ulb_host_cfg #(
    .NUM_HOSTS (NUM_HOSTS),
    .CFG_AW    (CFG_AW),
    .DATA_W    (DATA_W)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_int),
    .wr_en (cfg_wr_en),
    .wprot (cfg_wprot),
    .addr  (cfg_addr),
    .wmode (cfg_wdata[MODE_W-1:0]),
    .rdata (cfg_rdata),
    .modes (host_modes)
  );

  always_comb begin
    cur_mode = MODE_RESET;
    if (32'(host_id) < NUM_HOSTS) cur_mode = host_modes[host_id];
  end

  ulb_burst_track #(
    .SLOT_W (SLOT_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_int),
    .hready   (hready),
    .htrans   (htrans),
    .hburst   (hburst),
    .xfer     (xfer),
    .beat_nxt (beat_nxt),
    .slot_nxt (slot_nxt)
  );

  ulb_break_gen #(
    .SLOT_W (SLOT_W),
    .SEG_W  (SEG_W)
  ) u_brk (
    .clk        (clk),
    .rst_n      (rst_int),
    .xfer       (xfer),
    .mode       (cur_mode),
    .beat_nxt   (beat_nxt),
    .slot_nxt   (slot_nxt),
    .slot_limit (slot_limit),
    .addr_seg   (bnd_seg),
    .brk        (rearb_ok)
  );

endmodule

// File: rtl/ulb_break_limiter_chk.sv
module ulb_break_limiter_chk
  import ulb_pkg::*;
#(
  parameter int NUM_HOSTS = 13,
  parameter int HOST_W    = 4,
  parameter int CFG_AW    = 6,
  parameter int SEG_W     = 8
) (
  input logic                              clk,
  input logic                              rst_int,
  input logic                              cfg_wr_en,
  input logic                              cfg_wprot,
  input logic [CFG_AW-1:0]                 cfg_addr,
  input logic [NUM_HOSTS-1:0][MODE_W-1:0]  host_modes,
  input logic [HOST_W-1:0]                 host_id,
  input logic [1:0]                        htrans,
  input logic [2:0]                        hburst,
  input logic [SEG_W-1:0]                  bnd_seg,
  input logic                              hready,
  input logic                              rearb_ok
);

  logic              acc, incr, out_idx;
  logic [MODE_W-1:0] mode_seen;

  assign acc     = hready && (htrans == TR_NSEQ || htrans == TR_SEQ);
  assign incr    = (hburst == BT_INCR);
  assign out_idx = 32'(cfg_addr[CFG_AW-1:2]) >= NUM_HOSTS;

  always_comb begin
    mode_seen = MODE_RESET;
    if (32'(host_id) < NUM_HOSTS) mode_seen = host_modes[host_id];
  end

  assert_wprot_blocks_R3: assert property (@(posedge clk) disable iff (!rst_int)
    cfg_wr_en && cfg_wprot |=> $stable(host_modes));

  assert_out_of_range_R4: assert property (@(posedge clk) disable iff (!rst_int)
    cfg_wr_en && out_idx |=> $stable(host_modes));

  assert_single_every_beat_R5: assert property (@(posedge clk) disable iff (!rst_int)
    acc && incr && mode_seen == MODE_SINGLE |=> rearb_ok);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_int)
    !hready |=> $stable(rearb_ok));

  assert_boundary_break_R9: assert property (@(posedge clk) disable iff (!rst_int)
    acc && incr && (&bnd_seg) |=> rearb_ok);

  assert_fixed_no_break_R10: assert property (@(posedge clk) disable iff (!rst_int)
    acc && !incr |=> !rearb_ok);

  assert_idle_clears_R10: assert property (@(posedge clk) disable iff (!rst_int)
    hready && htrans == TR_IDLE |=> !rearb_ok);

endmodule

bind ulb_break_limiter ulb_break_limiter_chk #(
  .NUM_HOSTS (NUM_HOSTS),
  .HOST_W    (HOST_W),
  .CFG_AW    (CFG_AW),
  .SEG_W     (SEG_W)
) u_chk (
  .clk        (clk),
  .rst_int    (rst_int),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wprot  (cfg_wprot),
  .cfg_addr   (cfg_addr),
  .host_modes (host_modes),
  .host_id    (host_id),
  .htrans     (htrans),
  .hburst     (hburst),
  .bnd_seg    (bnd_seg),
  .hready     (hready),
  .rearb_ok   (rearb_ok)
);

// File: tb/sim_ulb_break_limiter.sv
`timescale 1ns/1ps
module sim_ulb_break_limiter;

  localparam logic [1:0] IDLE = 2'd0, BUSY = 2'd1, NSEQ = 2'd2, SEQ = 2'd3;
  localparam logic [2:0] INCR = 3'b001, INCR4 = 3'b011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_wprot = 1'b0;
  logic [31:0] cfg_rdata;
  logic [3:0]  host_id = '0;
  logic [1:0]  htrans = IDLE;
  logic [2:0]  hburst = INCR;
  logic [31:0] haddr = '0;
  logic        hready = 1'b1;
  logic [7:0]  slot_limit = '0;
  logic        rearb_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ulb_break_limiter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_wprot(cfg_wprot), .cfg_rdata(cfg_rdata),
    .host_id(host_id), .htrans(htrans), .hburst(hburst), .haddr(haddr),
    .hready(hready), .slot_limit(slot_limit), .rearb_ok(rearb_ok)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int host, input logic [31:0] data, input bit prot);
    @(negedge clk);
    htrans = IDLE; hready = 1'b1;
    cfg_addr = 6'(host * 4); cfg_wdata = data; cfg_wprot = prot; cfg_wr_en = 1'b1;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0; cfg_wprot = 1'b0;
  endtask

  task automatic cfg_read(input int host, output logic [31:0] val);
    cfg_addr = 6'(host * 4);
    #1 val = cfg_rdata;
  endtask

  task automatic xfer(input logic [1:0] tr, input logic [2:0] bt, input logic [31:0] a, input bit rdy);
    @(negedge clk);
    htrans = tr; hburst = bt; haddr = a; hready = rdy;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    xfer(IDLE, INCR, 32'h0, 1'b1);
  endtask

  function automatic bit exp_brk(input int mode, input int k, input int lim, input logic [31:0] a);
    int n;
    if (a[9:2] == 8'hFF) return 1'b1;
    if (mode == 0) return (lim != 0) && (k >= lim);
    n = (mode == 1) ? 1 : (1 << mode);
    return (k % n) == 0;
  endfunction

  task automatic run_burst(input int host, input int mode, input int lim,
                           input logic [31:0] start, input int nb, input string tag);
    logic [31:0] a;
    bit e;
    host_id = 4'(host); slot_limit = 8'(lim);
    for (int k = 1; k <= nb; k++) begin
      a = start + 32'(4 * (k - 1));
      xfer((k == 1) ? NSEQ : SEQ, INCR, a, 1'b1);
      e = exp_brk(mode, k, lim, a);
      chk(rearb_ok == e, $sformatf("%s beat %0d", tag, k), 32'(rearb_ok), 32'(e));
    end
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int h = 0; h < 13; h++) begin
      cfg_read(h, v);
      chk(v == 32'h4, $sformatf("R1 host %0d reset word", h), v, 32'h4);
    end
    chk(rearb_ok == 1'b0, "R1 rearb_ok after reset", 32'(rearb_ok), 0);
  endtask

  task automatic t_cfg_rw();
    logic [31:0] v;
    cfg_write(3, 32'hFFFF_FFFF, 1'b0);
    cfg_read(3, v);  chk(v == 32'h7, "R2 host 3 readback", v, 32'h7);
    cfg_read(2, v);  chk(v == 32'h4, "R2 host 2 untouched", v, 32'h4);
    cfg_write(12, 32'h0000_0102, 1'b0);
    cfg_read(12, v); chk(v == 32'h2, "R2 host 12 readback", v, 32'h2);
  endtask

  task automatic t_wprot();
    logic [31:0] v;
    cfg_write(3, 32'h1, 1'b1);
    cfg_read(3, v); chk(v == 32'h7, "R3 write under protect ignored", v, 32'h7);
  endtask

  task automatic t_range();
    logic [31:0] v;
    cfg_write(13, 32'h1, 1'b0);
    cfg_read(13, v); chk(v == 32'h0, "R4 read index 13", v, 32'h0);
    cfg_read(12, v); chk(v == 32'h2, "R4 host 12 unchanged", v, 32'h2);
    cfg_read(0, v);  chk(v == 32'h4, "R4 host 0 unchanged", v, 32'h4);
    cfg_write(15, 32'h0, 1'b0);
    cfg_read(12, v); chk(v == 32'h2, "R4 index 15 write ignored", v, 32'h2);
  endtask

  task automatic t_single();
    cfg_write(5, 32'h1, 1'b0);
    run_burst(5, 1, 0, 32'h100, 4, "R5 single access");
  endtask

  task automatic t_split();
    cfg_write(0, 32'h2, 1'b0);
    run_burst(0, 2, 0, 32'h000, 10, "R6 4-beat");
    cfg_write(0, 32'h3, 1'b0);
    run_burst(0, 3, 0, 32'h040, 17, "R6 8-beat");
    run_burst(4, 4, 0, 32'h080, 33, "R6 16-beat default");
    cfg_write(1, 32'h7, 1'b0);
    run_burst(1, 7, 0, 32'h000, 130, "R6 128-beat");
    cfg_write(0, 32'h2, 1'b0);
    host_id = 4'd0;
    xfer(NSEQ, INCR, 32'h200, 1'b1);
    xfer(SEQ,  INCR, 32'h204, 1'b1);
    run_burst(0, 2, 0, 32'h300, 4, "R6 restart on NONSEQ");
  endtask

  task automatic t_stall();
    host_id = 4'd0; slot_limit = '0;
    xfer(NSEQ, INCR, 32'h000, 1'b1); chk(rearb_ok == 1'b0, "R7 beat1", 32'(rearb_ok), 0);
    xfer(SEQ,  INCR, 32'h004, 1'b1); chk(rearb_ok == 1'b0, "R7 beat2", 32'(rearb_ok), 0);
    xfer(SEQ,  INCR, 32'h008, 1'b0); chk(rearb_ok == 1'b0, "R7 stalled not counted", 32'(rearb_ok), 0);
    xfer(SEQ,  INCR, 32'h008, 1'b1); chk(rearb_ok == 1'b0, "R7 beat3", 32'(rearb_ok), 0);
    xfer(SEQ,  INCR, 32'h00C, 1'b1); chk(rearb_ok == 1'b1, "R7 beat4 breaks", 32'(rearb_ok), 1);
    xfer(SEQ,  INCR, 32'h010, 1'b0); chk(rearb_ok == 1'b1, "R7 flag held in stall", 32'(rearb_ok), 1);
    xfer(BUSY, INCR, 32'h010, 1'b1); chk(rearb_ok == 1'b1, "R10 BUSY holds flag", 32'(rearb_ok), 1);
    idle();
  endtask

  task automatic t_unlimited();
    cfg_write(6, 32'h0, 1'b0);
    run_burst(6, 0, 5, 32'h000, 7, "R8 limit 5");
    run_burst(6, 0, 0, 32'h000, 8, "R8 limit 0 disabled");
    host_id = 4'd6; slot_limit = 8'd3;
    xfer(NSEQ, INCR, 32'h000, 1'b1); chk(rearb_ok == 1'b0, "R8 cycle 1", 32'(rearb_ok), 0);
    xfer(SEQ,  INCR, 32'h004, 1'b0); chk(rearb_ok == 1'b0, "R8 cycle 2 stalled", 32'(rearb_ok), 0);
    xfer(SEQ,  INCR, 32'h004, 1'b1); chk(rearb_ok == 1'b1, "R8 cycle 3 beat 2 breaks", 32'(rearb_ok), 1);
    idle();
  endtask

  task automatic t_boundary();
    run_burst(6, 0, 0, 32'h3F0, 6, "R9 unlimited at 1KB");
    run_burst(1, 7, 0, 32'h7F8, 3, "R9 128-beat at 1KB");
  endtask

  task automatic t_fixed();
    host_id = 4'd5;
    xfer(NSEQ, INCR4, 32'h000, 1'b1); chk(rearb_ok == 1'b0, "R10 INCR4 first", 32'(rearb_ok), 0);
    xfer(SEQ,  INCR4, 32'h3FC, 1'b1); chk(rearb_ok == 1'b0, "R10 INCR4 at boundary", 32'(rearb_ok), 0);
    xfer(NSEQ, INCR,  32'h100, 1'b1); chk(rearb_ok == 1'b1, "R10 INCR beat sets", 32'(rearb_ok), 1);
    xfer(IDLE, INCR,  32'h000, 1'b1); chk(rearb_ok == 1'b0, "R10 IDLE clears", 32'(rearb_ok), 0);
    xfer(NSEQ, INCR,  32'h100, 1'b1);
    xfer(NSEQ, 3'b000, 32'h200, 1'b1); chk(rearb_ok == 1'b0, "R10 single transfer clears", 32'(rearb_ok), 0);
    idle();
  endtask

  task automatic t_host_sel();
    host_id = 4'd0;
    xfer(NSEQ, INCR, 32'h100, 1'b1); chk(rearb_ok == 1'b0, "R11 host 0 mode 2 no break", 32'(rearb_ok), 0);
    idle();
    host_id = 4'd5;
    xfer(NSEQ, INCR, 32'h100, 1'b1); chk(rearb_ok == 1'b1, "R11 host 5 mode 1 break", 32'(rearb_ok), 1);
    idle();
  endtask

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #21 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_cfg_rw();
    t_wprot();
    t_range();
    t_single();
    t_split();
    t_stall();
    t_unlimited();
    t_boundary();
    t_fixed();
    t_host_sel();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule